// File: doc/BRIEF.md
# Quad Converter Code Latch Bus Interface

This block sits between an 8-bit microprocessor-style bus and four converter channels, named A, B, C and D. Each channel has its own 8-bit code register, and each register's value goes to its own parallel output. One shared data port serves all four registers. The port is split into an input, an output and an output enable, so the pad or tri-state logic around the block can form the bidirectional pin.

Each access is decoded from four signals: two active-low strobes, a pair-select line and a read/write line. Strobe 1 addresses the A/B pair and strobe 2 addresses the C/D pair. With pair-select high the access goes to A or C; with it low the access goes to B or D.

A write with one strobe low updates one register. A write with both strobes low updates two registers at once. A read with one strobe low returns the selected register's code on the bus. Every other combination leaves all registers unchanged and the bus undriven.

The design is synchronous, so the open-latch behaviour is modelled cycle by cycle. While a write stays active, the selected register reloads from the bus on every clock. When the write ends, the register keeps the last value it sampled. Reset is asynchronous and active-low.

Top module: `quad_latch_bus`

## Requirements
- R1: While rst_ni is low, all four codes are 0, data_oe_o is 0 and data_o is 0.
- R2: With ds1_ni=0, ds2_ni=1 and rd_nwr_i=0, data_i is written to A when pair_sel_i=1 and to B when pair_sel_i=0. The written code appears one clock after the edge that samples the write.
- R3: With ds1_ni=1, ds2_ni=0 and rd_nwr_i=0, data_i is written to C when pair_sel_i=1 and to D when pair_sel_i=0. The same one-clock timing as R2 applies.
- R4: With both strobes low and rd_nwr_i=0, data_i is written to A and C together when pair_sel_i=1, and to B and D together when pair_sel_i=0. No other register changes.
- R5: While a write condition stays active over several clocks, the selected code follows data_i on every clock, one cycle behind.
- R6: After the write condition ends, the code keeps the last value sampled during the write. This holds whether rd_nwr_i rises or the strobe rises.
- R7: With exactly one strobe low and rd_nwr_i=1, the next cycle has data_oe_o=1 and data_o equal to the selected register's code. The selection uses the same pair and pair_sel_i decode as R2 and R3.
- R8: With both strobes high, no code changes and data_oe_o is 0 on the next cycle, for any pair_sel_i and rd_nwr_i.
- R9: With both strobes low and rd_nwr_i=1, no code changes and data_oe_o is 0 on the next cycle.
- R10: data_o is 0 whenever data_oe_o is 0.
- R11: codes_o packs A in bits [7:0], B in [15:8], C in [23:16] and D in [31:24].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ds1_ni | input | 1 | Strobe for the A/B pair, active low |
| ds2_ni | input | 1 | Strobe for the C/D pair, active low |
| pair_sel_i | input | 1 | 1 selects A or C, 0 selects B or D |
| rd_nwr_i | input | 1 | 1 means read, 0 means write |
| data_i | input | 8 | Bus data into the block, bit 0 is the LSB |
| data_o | output | 8 | Readback data, 0 when not driving |
| data_oe_o | output | 1 | Bus output enable |
| codes_o | output | 4x8 | Held codes A..D, packed |

## Verification
Every result, whether a code update, a readback value or a change in the output enable, is due exactly one clock after the edge that samples the controlling inputs. The bench drives inputs on the falling edge and reads outputs on the next falling edge. That edge comes half a period after the one register stage has loaded. Multi-cycle writes are checked cycle by cycle with this same lag. Retention is checked on the cycle after the write condition ends, including the case where read/write rises first and turns the access into a readback of the value just kept.

// File: rtl/qb_pkg.sv
package qb_pkg;
  localparam int NUM_CH = 4;
  localparam int CH_A = 0;
  localparam int CH_B = 1;
  localparam int CH_C = 2;
  localparam int CH_D = 3;

  typedef struct packed {
    logic [NUM_CH-1:0] wr_en;
    logic [NUM_CH-1:0] rd_sel;
  } access_t;
endpackage

// File: rtl/qb_decode.sv
module qb_decode
  import qb_pkg::*;
(
  input  logic    ds1_ni,
  input  logic    ds2_ni,
  input  logic    pair_sel_i,
  input  logic    rd_nwr_i,
  output access_t acc_o
);
  logic [1:0] pair_hit;  // [0]=A/B pair, [1]=C/D pair
  logic       single;

  always_comb begin
    pair_hit = {~ds2_ni, ~ds1_ni};
    single   = ^pair_hit;
    acc_o    = '0;
    // writes: one pair or both pairs (broadcast)
    if (!rd_nwr_i) begin
      if (pair_hit[0]) acc_o.wr_en[pair_sel_i ? CH_A : CH_B] = 1'b1;
      if (pair_hit[1]) acc_o.wr_en[pair_sel_i ? CH_C : CH_D] = 1'b1;
    end else if (single) begin
      // reads only with exactly one strobe
      if (pair_hit[0]) acc_o.rd_sel[pair_sel_i ? CH_A : CH_B] = 1'b1;
      else             acc_o.rd_sel[pair_sel_i ? CH_C : CH_D] = 1'b1;
    end
  end
endmodule

// File: rtl/qb_latch_bank.sv
module qb_latch_bank
  import qb_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [NUM_CH-1:0]             wr_en_i,
  input  logic [DATA_W-1:0]             data_i,
  output logic [NUM_CH-1:0][DATA_W-1:0] code_o
);
  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic [DATA_W-1:0] code_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         code_q <= '0;
      else if (wr_en_i[g]) code_q <= data_i;
    end

    assign code_o[g] = code_q;

    // R5
    follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_en_i[g] |=> code_o[g] == $past(data_i));
    // R6
    retain_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !wr_en_i[g] |=> $stable(code_o[g]));
  end
endmodule

// File: rtl/qb_readback.sv
module qb_readback
  import qb_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [NUM_CH-1:0]             rd_sel_i,
  input  logic [NUM_CH-1:0][DATA_W-1:0] code_i,
  output logic [DATA_W-1:0]             data_o,
  output logic                          data_oe_o
);
  logic [DATA_W-1:0] rd_mux;
  logic [DATA_W-1:0] data_q;
  logic              oe_q;

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NUM_CH; i++)
      if (rd_sel_i[i]) rd_mux |= code_i[i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      oe_q   <= 1'b0;
    end else begin
      oe_q   <= |rd_sel_i;
      data_q <= rd_mux;
    end
  end

  assign data_o    = data_q;
  assign data_oe_o = oe_q;

  // R10
  quiet_bus_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !data_oe_o |-> data_o == '0);
  // R7
  read_drive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|rd_sel_i) |=> data_oe_o);
endmodule

// File: rtl/quad_latch_bus.sv
module quad_latch_bus
  import qb_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          ds1_ni,
  input  logic                          ds2_ni,
  input  logic                          pair_sel_i,
  input  logic                          rd_nwr_i,
  input  logic [DATA_W-1:0]             data_i,
  output logic [DATA_W-1:0]             data_o,
  output logic                          data_oe_o,
  output logic [NUM_CH-1:0][DATA_W-1:0] codes_o
);
  access_t acc;

  qb_decode u_decode (
    .ds1_ni    (ds1_ni),
    .ds2_ni    (ds2_ni),
    .pair_sel_i(pair_sel_i),
    .rd_nwr_i  (rd_nwr_i),
    .acc_o     (acc)
  );

  qb_latch_bank #(.DATA_W(DATA_W)) u_bank (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_en_i(acc.wr_en),
    .data_i (data_i),
    .code_o (codes_o)
  );

  qb_readback #(.DATA_W(DATA_W)) u_rdbk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rd_sel_i (acc.rd_sel),
    .code_i   (codes_o),
    .data_o   (data_o),
    .data_oe_o(data_oe_o)
  );

  // R4
  wr_fanout_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(acc.wr_en) <= 2);
  // R7
  rd_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(acc.rd_sel) && !((|acc.rd_sel) && (|acc.wr_en)));
  // R8
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ds1_ni && ds2_ni) |=> !data_oe_o && $stable(codes_o));
  // R9
  dual_read_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ds1_ni && !ds2_ni && rd_nwr_i) |=> !data_oe_o && $stable(codes_o));
endmodule

// File: tb/quad_latch_bus_test.sv
module quad_latch_bus_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ds1_n = 1'b1, ds2_n = 1'b1, psel = 1'b0, rdnwr = 1'b0;
  logic [7:0] din = '0;
  logic [7:0] dout;
  logic       doe;
  logic [3:0][7:0] codes;

  logic [7:0] exp_code [4];
  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit done = 0;

  always #5 clk = ~clk;

  quad_latch_bus uut (
    .clk_i(clk), .rst_ni(rst_n), .ds1_ni(ds1_n), .ds2_ni(ds2_n),
    .pair_sel_i(psel), .rd_nwr_i(rdnwr), .data_i(din),
    .data_o(dout), .data_oe_o(doe), .codes_o(codes)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d cycles expected<=20000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive on falling edge, observe one clock later on the next falling edge
  task automatic step(input logic d1, input logic d2, input logic s,
                      input logic rw, input logic [7:0] d);
    @(negedge clk);
    ds1_n = d1; ds2_n = d2; psel = s; rdnwr = rw; din = d;
    @(negedge clk);
  endtask

  task automatic idle();
    step(1'b1, 1'b1, 1'b0, 1'b0, 8'h00);
  endtask

  task automatic chk_codes(input string req);
    for (int i = 0; i < 4; i++) chk(req, codes[i], exp_code[i]);
  endtask

  task automatic chk_quiet(input string req);
    chk(req, doe, 1'b0);
    chk({req, "/R10"}, dout, 8'h00);
  endtask

  task automatic t_reset();
    @(negedge clk);
    for (int i = 0; i < 4; i++) exp_code[i] = 8'h00;
    chk_codes("R1");
    chk("R1", {doe, dout}, 9'h000);
    rst_n = 1'b1;
  endtask

  task automatic t_single_writes();
    step(1'b0, 1'b1, 1'b1, 1'b0, 8'h11); exp_code[0] = 8'h11; chk_codes("R2 write A");
    step(1'b0, 1'b1, 1'b0, 1'b0, 8'h22); exp_code[1] = 8'h22; chk_codes("R2 write B");
    step(1'b1, 1'b0, 1'b1, 1'b0, 8'h33); exp_code[2] = 8'h33; chk_codes("R3 write C");
    step(1'b1, 1'b0, 1'b0, 1'b0, 8'h44); exp_code[3] = 8'h44; chk_codes("R3 write D");
    idle();
    // R11: packed lane positions
    chk("R11", codes, 32'h44332211);
  endtask

  task automatic t_reads();
    for (int i = 0; i < 4; i++) begin
      step(i < 2 ? 1'b0 : 1'b1, i < 2 ? 1'b1 : 1'b0, (i % 2) == 0, 1'b1, 8'hC3);
      chk("R7 oe", doe, 1'b1);
      chk("R7 data", dout, exp_code[i]);
      chk_codes("R7 no change");
    end
    idle();
    chk_quiet("R7 release");
  endtask

  task automatic t_hold_rows();
    for (int k = 0; k < 4; k++) begin
      step(1'b1, 1'b1, k[0], k[1], 8'hFF);
      chk_codes("R8 hold");
      chk_quiet("R8");
    end
    for (int k = 0; k < 2; k++) begin
      step(1'b0, 1'b0, k[0], 1'b1, 8'hEE);
      chk_codes("R9 hold");
      chk_quiet("R9");
    end
  endtask

  task automatic t_broadcast();
    step(1'b0, 1'b0, 1'b1, 1'b0, 8'h5A);
    exp_code[0] = 8'h5A; exp_code[2] = 8'h5A;
    chk_codes("R4 A&C");
    step(1'b0, 1'b0, 1'b0, 1'b0, 8'hA5);
    exp_code[1] = 8'hA5; exp_code[3] = 8'hA5;
    chk_codes("R4 B&D");
    for (int i = 0; i < 4; i++) begin
      step(i < 2 ? 1'b0 : 1'b1, i < 2 ? 1'b1 : 1'b0, (i % 2) == 0, 1'b1, 8'h00);
      chk("R4 readback", {doe, dout}, {1'b1, exp_code[i]});
    end
    idle();
  endtask

  task automatic t_transparent();
    logic [7:0] seq [3] = '{8'h01, 8'h80, 8'h7E};
    @(negedge clk);
    ds1_n = 1'b1; ds2_n = 1'b0; psel = 1'b0; rdnwr = 1'b0;
    foreach (seq[i]) begin
      din = seq[i];
      @(negedge clk);
      exp_code[3] = seq[i];
      chk_codes("R5 follow D");
    end
    // read/write rises first, strobe still low: becomes readback of kept value
    rdnwr = 1'b1; din = 8'hEE;
    @(negedge clk);
    chk_codes("R6 kept after rw rise");
    chk("R6 readback", {doe, dout}, {1'b1, 8'h7E});
    ds2_n = 1'b1; din = 8'h99;
    @(negedge clk);
    chk_codes("R6 kept after strobe rise");
    chk_quiet("R8 after read");
    // write ends by strobe rising
    step(1'b0, 1'b1, 1'b1, 1'b0, 8'h3C); exp_code[0] = 8'h3C;
    ds1_n = 1'b1; din = 8'hC3;
    @(negedge clk);
    chk_codes("R6 kept after strobe end");
  endtask

  initial begin
    t_reset();
    t_single_writes();
    t_reads();
    t_hold_rows();
    t_broadcast();
    t_transparent();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule